// File: doc/BRIEF.md
# Buffered Serial-Flash Page Program Engine

This block issues a single program transaction to a serial NOR flash over single-lane SPI (mode 0). Software loads an opcode, a 3- or 4-byte target address and, depending on the mode, either one data byte or a full 128-byte page, then starts the write with one control bit. The engine sends opcode, address and data in one chip-select window. The control bit reads back as set until that window closes.

In buffered mode, page data arrives on a 32-bit valid/ready stream. Each accepted word supplies four consecutive page bytes, with the lowest-addressed byte in bits 7:0. `page_ready` is high only while buffered mode is in force and no write is running. At all other times the stream is back-pressured and `page_valid` may be held. Once the page holds 128 bytes, further accepted words are discarded.

A mode change requested through the register port takes effect only while the engine is idle. Software polls the mode bit until it reads back the new value. The write-enable and status-poll suppression bits are stored and can be read back. The engine itself always emits only the program transaction.

Top module: `pgm_engine`

Register map (8-bit registers, selected by `reg_addr`): 0 = control (bit 4 start/busy), 1 = opcode, 2..5 = address bytes from least to most significant, 6 = single data byte, 7 = mode (bit 0 buffered, bit 5 no status poll, bit 7 no write-enable), 8 = bus (bit 4 four-byte address). Unmapped addresses read 0.

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `page_ready` is 0 and every register reads 0.
- R2: Writing mode bit 0 while idle makes it read back with the new value exactly one clock after the write is accepted. A change written while a write is running is held back until that write completes.
- R3: `page_ready` is 1 exactly when buffered mode is in force and no write is running. An accepted word places its bits 7:0 at the next page byte, then bits 15:8, 23:16 and 31:24.
- R4: A buffered write sends opcode, address and then exactly 128 page bytes from index 0 upward, all in one chip-select window.
- R5: Once 32 words have been accepted, further accepted words change no page byte.
- R6: The page fill position returns to byte 0 after each completed write and on every entry into buffered mode. Bytes that are not refilled keep their earlier values.
- R7: An unbuffered write sends opcode, address and the single byte from register 6 in one window.
- R8: When bus bit 4 is 1, the address is sent as four bytes from register 5 down to register 2. When it is 0, three bytes are sent from register 4 down to register 2.
- R9: Control bit 4 reads 1 from the clock after a start is accepted until the window has closed. A start written while busy is ignored.
- R10: SPI is mode 0 and MSB first. `spi_sclk` idles low, `spi_mosi` changes only while `spi_sclk` is low, and each bit lasts 2*SCK_HALF clocks.
- R11: Mode bits 5 and 7 read back as written. Each start produces exactly one chip-select window, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| page_valid | input | 1 | Page word offered |
| page_data | input | 32 | Page word, little-endian bytes |
| page_ready | output | 1 | Page word accepted when high with valid |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI serial data out |

## Verification
The assertions assume that the sequencer refills the one-byte holding register long before the current byte finishes shifting. They also assume that the mode register changes only through a register write, so the applied mode is frozen for the whole window. The stimulus writes registers one strobe at a time and holds `page_valid` with stable data until `page_ready` is seen. It issues extra starts and mode changes only while a window is open, which exercises the deferral rules without leaving the input contract.

// File: rtl/pgm_pkg.sv
`timescale 1ns/1ps
package pgm_pkg;
  localparam logic [3:0] RA_CTRL  = 4'd0;
  localparam logic [3:0] RA_OPC   = 4'd1;
  localparam logic [3:0] RA_ADR0  = 4'd2;
  localparam logic [3:0] RA_WBYTE = 4'd6;
  localparam logic [3:0] RA_MODE  = 4'd7;
  localparam logic [3:0] RA_BUS   = 4'd8;
  localparam int ADR_REGS     = 4;
  localparam int CTRL_GO_BIT  = 4;
  localparam int MODE_BUF_BIT = 0;
  localparam int MODE_NOPOLL  = 5;
  localparam int MODE_NOWREN  = 7;
  localparam int BUS_WIDE_BIT = 4;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/pgm_page_buf.sv
`timescale 1ns/1ps
module pgm_page_buf #(
  parameter int PAGE_BYTES = 128,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [8*WORD_BYTES-1:0] wr_word,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [7:0]              rd_byte
);
  localparam int WORDS = PAGE_BYTES / WORD_BYTES;
  localparam int IW    = $clog2(WORDS);
  localparam int PW    = $clog2(WORDS + 1);
  localparam int BW    = $clog2(PAGE_BYTES);
  localparam int LW    = $clog2(WORD_BYTES);

  logic [8*WORD_BYTES-1:0] mem [WORDS];
  logic [PW-1:0]           wptr;
  logic                    full;
  logic [8*WORD_BYTES-1:0] rd_word;

  assign full = (wptr == PW'(WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (clr) begin
      wptr <= '0;
    end else if (wr_en && !full) begin
      mem[wptr[IW-1:0]] <= wr_word;
      wptr <= wptr + PW'(1);
    end
  end

  assign rd_word = mem[rd_idx[BW-1:LW]];
  assign rd_byte = rd_word[{rd_idx[LW-1:0], 3'b000} +: 8];

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);
endmodule

// File: rtl/pgm_spi_tx.sv
`timescale 1ns/1ps
module pgm_spi_tx #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  input  logic       tx_last,
  output logic       tx_ready,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n
);
  localparam int CW = $clog2(SCK_HALF + 1);

  logic [7:0]    hold, shreg;
  logic          hold_last, hold_full, last_r;
  logic          active, loaded, phase;
  logic [CW-1:0] hcnt;
  logic [2:0]    bidx;
  logic          half_end, byte_end, do_load;

  assign half_end = (hcnt == CW'(SCK_HALF - 1));
  assign byte_end = active && loaded && half_end && phase && (bidx == 3'd7);
  assign do_load  = hold_full && (!active || !loaded || (byte_end && !last_r));
  assign tx_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0; hold_last <= 1'b0; hold_full <= 1'b0;
      shreg <= '0; last_r <= 1'b0; active <= 1'b0; loaded <= 1'b0;
      phase <= 1'b0; hcnt <= '0; bidx <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tx_valid && !hold_full) begin
        hold      <= tx_data;
        hold_last <= tx_last;
        hold_full <= 1'b1;
      end
      if (do_load) begin
        shreg     <= hold;
        last_r    <= hold_last;
        hold_full <= 1'b0;
        active    <= 1'b1;
        loaded    <= 1'b1;
        phase     <= 1'b0;
        hcnt      <= '0;
        bidx      <= '0;
      end else if (active && loaded) begin
        if (!half_end) begin
          hcnt <= hcnt + CW'(1);
        end else begin
          hcnt <= '0;
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (bidx == 3'd7) begin
              loaded <= 1'b0;
              if (last_r) begin
                active <= 1'b0;
                done   <= 1'b1;
              end
            end else begin
              shreg <= {shreg[6:0], 1'b0};
              bidx  <= bidx + 3'd1;
            end
          end
        end
      end
    end
  end

  assign cs_n = !active;
  assign sclk = active && loaded && phase;
  assign mosi = shreg[7];

  // R10
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R4
  done_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));
endmodule

// File: rtl/pgm_seq.sv
`timescale 1ns/1ps
module pgm_seq #(
  parameter int PAGE_BYTES = 128,
  parameter int ADDR_MAX   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic                    buf_mode,
  input  logic                    wide_addr,
  input  logic [7:0]              opcode,
  input  logic [8*ADDR_MAX-1:0]   addr,
  input  logic [7:0]              wbyte,
  input  logic [7:0]              buf_byte,
  output logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
  output logic                    tx_valid,
  output logic [7:0]              tx_data,
  output logic                    tx_last,
  input  logic                    tx_ready,
  input  logic                    tx_done,
  output logic                    busy,
  output logic                    finished
);
  import pgm_pkg::*;
  localparam int TW = $clog2(ADDR_MAX + PAGE_BYTES + 3);
  localparam int BW = $clog2(PAGE_BYTES);

  seq_state_e              state;
  logic [TW-1:0]           idx, total, nab, aoff;
  logic                    mode_r, wide_r;
  logic [8*ADDR_MAX-1:0]   ashift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE; idx <= '0; total <= '0; mode_r <= 1'b0; wide_r <= 1'b0;
    end else if (state == SEQ_IDLE) begin
      if (go) begin
        state  <= SEQ_RUN;
        idx    <= '0;
        mode_r <= buf_mode;
        wide_r <= wide_addr;
        total  <= TW'(1) + (wide_addr ? TW'(ADDR_MAX) : TW'(ADDR_MAX - 1))
                         + (buf_mode ? TW'(PAGE_BYTES) : TW'(1));
      end
    end else begin
      if (tx_valid && tx_ready) idx <= idx + TW'(1);
      if (tx_done) state <= SEQ_IDLE;
    end
  end

  assign busy     = (state == SEQ_RUN);
  assign finished = busy && tx_done;
  assign nab      = wide_r ? TW'(ADDR_MAX) : TW'(ADDR_MAX - 1);
  assign aoff     = nab - idx;
  assign ashift   = addr >> {aoff, 3'b000};
  assign buf_idx  = BW'(idx - nab - TW'(1));
  assign tx_valid = busy && (idx < total);
  assign tx_last  = (idx == total - TW'(1));

  always_comb begin
    if (idx == '0)      tx_data = opcode;
    else if (idx <= nab) tx_data = ashift[7:0];
    else if (mode_r)    tx_data = buf_byte;
    else                tx_data = wbyte;
  end

  // R4
  last_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);
endmodule

// File: rtl/pgm_engine.sv
`timescale 1ns/1ps
module pgm_engine #(
  parameter int PAGE_BYTES = 128,
  parameter int WORD_BYTES = 4,
  parameter int SCK_HALF   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [3:0]              reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    page_valid,
  input  logic [8*WORD_BYTES-1:0] page_data,
  output logic                    page_ready,
  output logic                    spi_sclk,
  output logic                    spi_cs_n,
  output logic                    spi_mosi
);
  import pgm_pkg::*;
  localparam int BW = $clog2(PAGE_BYTES);

  logic [7:0]            opc_q, wbyte_q;
  logic [7:0]            adr_q [ADR_REGS];
  logic [8*ADR_REGS-1:0] addr_vec;
  logic                  buf_req, buf_mode, no_poll, no_wren, wide_q;
  logic                  go, busy, finished, buf_clr;
  logic [BW-1:0]         buf_idx;
  logic [7:0]            buf_byte, tx_data;
  logic                  tx_valid, tx_last, tx_ready, tx_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_q <= '0; wbyte_q <= '0; buf_req <= 1'b0; buf_mode <= 1'b0;
      no_poll <= 1'b0; no_wren <= 1'b0; wide_q <= 1'b0;
      for (int i = 0; i < ADR_REGS; i++) adr_q[i] <= '0;
    end else begin
      if (!busy) buf_mode <= buf_req;
      if (reg_we) begin
        case (reg_addr)
          RA_OPC:   opc_q   <= reg_wdata;
          RA_WBYTE: wbyte_q <= reg_wdata;
          RA_MODE: begin
            buf_req <= reg_wdata[MODE_BUF_BIT];
            no_poll <= reg_wdata[MODE_NOPOLL];
            no_wren <= reg_wdata[MODE_NOWREN];
          end
          RA_BUS:   wide_q  <= reg_wdata[BUS_WIDE_BIT];
          default: begin
            for (int i = 0; i < ADR_REGS; i++)
              if (reg_addr == RA_ADR0 + 4'(i)) adr_q[i] <= reg_wdata;
          end
        endcase
      end
    end
  end

  for (genvar g = 0; g < ADR_REGS; g++) begin : g_addr
    assign addr_vec[8*g +: 8] = adr_q[g];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:  reg_rdata[CTRL_GO_BIT] = busy;
      RA_OPC:   reg_rdata = opc_q;
      RA_WBYTE: reg_rdata = wbyte_q;
      RA_MODE: begin
        reg_rdata[MODE_BUF_BIT] = buf_mode;
        reg_rdata[MODE_NOPOLL]  = no_poll;
        reg_rdata[MODE_NOWREN]  = no_wren;
      end
      RA_BUS:   reg_rdata[BUS_WIDE_BIT] = wide_q;
      default: begin
        for (int i = 0; i < ADR_REGS; i++)
          if (reg_addr == RA_ADR0 + 4'(i)) reg_rdata = adr_q[i];
      end
    endcase
  end

  assign go         = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CTRL_GO_BIT];
  assign page_ready = buf_mode && !busy;
  assign buf_clr    = finished || (!busy && buf_req && !buf_mode);

  pgm_page_buf #(.PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr),
    .wr_en(page_valid && page_ready), .wr_word(page_data),
    .rd_idx(buf_idx), .rd_byte(buf_byte));

  pgm_seq #(.PAGE_BYTES(PAGE_BYTES), .ADDR_MAX(ADR_REGS)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .buf_mode(buf_mode), .wide_addr(wide_q),
    .opcode(opc_q), .addr(addr_vec), .wbyte(wbyte_q), .buf_byte(buf_byte),
    .buf_idx(buf_idx), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_done(tx_done), .busy(busy), .finished(finished));

  pgm_spi_tx #(.SCK_HALF(SCK_HALF)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .done(tx_done),
    .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n));

  // R9
  go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> spi_cs_n);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(buf_mode));
endmodule

// File: tb/pgm_engine_tb_top.sv
`timescale 1ns/1ps
module pgm_engine_tb_top;
  localparam int HALF = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic page_valid = 1'b0;
  logic [31:0] page_data = '0;
  logic page_ready, spi_sclk, spi_cs_n, spi_mosi;

  always #2.5 clk = ~clk;

  pgm_engine #(.PAGE_BYTES(128), .WORD_BYTES(4), .SCK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_valid(page_valid),
    .page_data(page_data), .page_ready(page_ready), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi));

  int n_chk = 0, n_bad = 0;
  bit finished_run = 0;
  string cur_req = "R7";
  logic [7:0] exp_q[$];
  int len_q[$];
  logic [31:0] model [32];
  int mptr = 0;
  logic [7:0] opc = 8'h02, wb = 8'hA5;
  logic [7:0] adr [4] = '{8'h12, 8'h34, 8'h56, 8'h9A};
  bit wide = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: rebuilds bytes from the SPI pins and scores them
  int cyc = 0, last_rise = -1, nbits = 0, nbytes = 0, per_err = 0, mode_err = 0;
  logic [7:0] shv = '0;
  logic prv_sclk = 1'b0, prv_cs = 1'b1, prv_mosi = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!spi_cs_n) begin
        if (spi_sclk && !prv_sclk) begin
          shv = {shv[6:0], spi_mosi};
          nbits++;
          if (last_rise >= 0 && (cyc - last_rise) != 2*HALF) per_err++;
          last_rise = cyc;
          if (nbits % 8 == 0) begin
            nbytes++;
            if (exp_q.size() == 0) chk(0, "R11", "unexpected byte", shv, 0);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(shv == e, cur_req, $sformatf("byte %0d", nbytes-1), shv, e);
            end
          end
        end
        if (spi_sclk && prv_sclk && spi_mosi != prv_mosi) mode_err++;
      end
      if (spi_cs_n && !prv_cs) begin
        if (len_q.size() == 0) chk(0, "R11", "unexpected window", nbytes, 0);
        else begin
          int l;
          l = len_q.pop_front();
          chk(nbytes == l && nbits == 8*l, "R4", "window byte count", nbytes, l);
        end
        chk(per_err == 0, "R10", "bit period errors", per_err, 0);
        chk(mode_err == 0, "R10", "mosi changed with sclk high", mode_err, 0);
        nbits = 0; nbytes = 0; per_err = 0; mode_err = 0; last_rise = -1;
      end
    end
    prv_sclk = spi_sclk; prv_cs = spi_cs_n; prv_mosi = spi_mosi;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); page_valid = 1'b1; page_data = w;
    while (!page_ready) @(negedge clk);
    @(negedge clk); page_valid = 1'b0;
    if (mptr < 32) model[mptr] = w;
    mptr++;
  endtask

  // driver side of the scoreboard
  task automatic expect_txn(input bit bufd);
    int n;
    n = 0;
    exp_q.push_back(opc); n++;
    for (int i = (wide ? 3 : 2); i >= 0; i--) begin exp_q.push_back(adr[i]); n++; end
    if (bufd) for (int k = 0; k < 128; k++) begin
      exp_q.push_back(model[k/4][8*(k%4) +: 8]); n++;
    end
    else begin exp_q.push_back(wb); n++; end
    len_q.push_back(n);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    forever begin
      rd(4'd0, v);
      if (!v[4]) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    mptr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);
    chk(page_ready == 1'b0, "R1", "page_ready", page_ready, 0);
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v); chk(v == 8'h00, "R1", $sformatf("reg %0d", a), v, 0);
    end
    wr(4'd1, opc); wr(4'd6, wb);
    for (int i = 0; i < 4; i++) wr(4'(2+i), adr[i]);

    // R7 unbuffered, 3-byte address; R9 busy flag and ignored restart
    cur_req = "R7";
    expect_txn(0);
    wr(4'd0, 8'h10);
    rd(4'd0, v); chk(v[4] == 1'b1, "R9", "busy after start", v[4], 1);
    wr(4'd0, 8'h10);
    wait_idle();
    rd(4'd0, v); chk(v[4] == 1'b0, "R9", "busy cleared", v[4], 0);
    chk(exp_q.size() == 0 && len_q.size() == 0, "R9", "restart ignored", exp_q.size(), 0);

    // R8 4-byte address
    wr(4'd8, 8'h10);
    rd(4'd8, v); chk(v == 8'h10, "R8", "bus readback", v, 8'h10);
    wide = 1; cur_req = "R8";
    expect_txn(0);
    wr(4'd0, 8'h10); wait_idle();

    // R11 suppression bits stored, still one window per start
    wr(4'd7, 8'hA0);
    rd(4'd7, v); chk(v == 8'hA0, "R11", "mode readback", v, 8'hA0);
    opc = 8'h03; wr(4'd1, opc); cur_req = "R11";
    expect_txn(0);
    wr(4'd0, 8'h10); wait_idle();
    chk(len_q.size() == 0, "R11", "single window", len_q.size(), 0);

    // R2 mode handshake, R3 ready and little-endian fill
    wr(4'd7, 8'hA1);
    rd(4'd7, v); chk(v[0] == 1'b0, "R2", "mode not yet applied", v[0], 0);
    @(negedge clk);
    rd(4'd7, v); chk(v == 8'hA1, "R2", "mode applied", v, 8'hA1);
    chk(page_ready == 1'b1, "R3", "ready in buffered idle", page_ready, 1);
    mptr = 0;
    for (int i = 0; i < 32; i++) push_word((32'(i) * 32'h04040404 + 32'h03020100) ^ 32'hC3C3C3C3);
    opc = 8'h32; wr(4'd1, opc); cur_req = "R3";
    expect_txn(1);
    wr(4'd0, 8'h10);
    chk(page_ready == 1'b0, "R3", "ready low while busy", page_ready, 0);
    wait_idle();

    // R6 pointer reset after completion; R2 deferred mode change
    for (int i = 0; i < 4; i++) push_word(32'hA0B0C0D0 + 32'(i));
    cur_req = "R6";
    expect_txn(1);
    wr(4'd0, 8'h10);
    wr(4'd7, 8'hA0);
    repeat (2) @(negedge clk);
    rd(4'd7, v); chk(v[0] == 1'b1, "R2", "mode held while busy", v[0], 1);
    wait_idle();
    rd(4'd7, v); chk(v[0] == 1'b0, "R2", "mode applied after write", v[0], 0);
    chk(page_ready == 1'b0, "R3", "ready low when unbuffered", page_ready, 0);

    // R5 extra words dropped
    wr(4'd7, 8'hA1); @(negedge clk);
    for (int i = 0; i < 32; i++) push_word(32'h11111111 * 32'(i % 15) ^ 32'h5A000000 + 32'(i));
    push_word(32'hDEADBEEF); push_word(32'h0BADF00D);
    cur_req = "R5";
    expect_txn(1);
    wr(4'd0, 8'h10); wait_idle();

    // R6 pointer reset on entry into buffered mode
    for (int i = 0; i < 3; i++) push_word(32'h77665544 + 32'(i));
    wr(4'd7, 8'hA0); repeat (2) @(negedge clk);
    wr(4'd7, 8'hA1); @(negedge clk);
    mptr = 0;
    push_word(32'hFEEDC0DE);
    cur_req = "R6";
    expect_txn(1);
    wr(4'd0, 8'h10); wait_idle();

    chk(exp_q.size() == 0 && len_q.size() == 0, "R11", "all expected windows seen", exp_q.size(), 0);
    finished_run = 1;
    summary();
    $finish;
  end
endmodule